// File: doc/BRIEF.md
# Load/Store Byte-Lane Aligner

This purely combinational block sits between a processor core and a 32-bit data memory that is addressed by whole words. It adds a base register value and a signed offset to form the byte address of an access, presents the word part of that address to the memory, and uses the two lowest address bits to select which byte lanes the access touches.

For stores it turns the access size into a four-bit write mask and repeats the narrow store value across the data bus so that the selected lanes carry it. For loads it picks the addressed byte, half-word or word out of the word the memory returns, then sign-extends or zero-extends it to 32 bits. Between them the size code and the unsigned flag cover the five load forms (signed byte, unsigned byte, signed half, unsigned half, word) and the three store forms (byte, half, word). Misaligned addresses are not trapped: any low address bits that a wider access does not use are ignored.

Top module: `lsu_lane_aligner`

## Requirements
- R1: `mem_addr_o` equals bits [31:2] of `base_i + offset_i`, where the sum wraps modulo 2^32 and a negative offset is given in two's complement.
- R2: A byte store (size code 00) with `store_en_i` high sets only write-mask bit `k`, where `k` is address bits [1:0] and lane `k` is data bits [8k+7:8k]. `wdata_o` carries `store_data_i[7:0]` in all four lanes.
- R3: A half-word store (size code 01) sets mask 4'b0011 when address bit 1 is 0 and 4'b1100 when it is 1. `wdata_o` carries `store_data_i[15:0]` in both halves, and address bit 0 has no effect.
- R4: A word store (size code 10) sets mask 4'b1111 and drives `store_data_i` unchanged, whatever the value of address bits [1:0].
- R5: With `store_en_i` low the write mask is 4'b0000, whatever the size and address.
- R6: A byte load with `unsigned_i` = 0 returns the byte in lane `k` (address bits [1:0]) of `mem_rdata_i`, with bit 7 of that byte copied into bits [31:8].
- R7: A byte load with `unsigned_i` = 1 returns the byte in lane `k` with bits [31:8] zero.
- R8: A half-word load returns `mem_rdata_i[15:0]` when address bit 1 is 0 and `mem_rdata_i[31:16]` when it is 1, ignoring address bit 0. Bits [31:16] of the result are copies of bit 15 when `unsigned_i` = 0 and are zero when `unsigned_i` = 1.
- R9: A word load returns `mem_rdata_i` unchanged, and `unsigned_i` has no effect on it.
- R10: With `load_en_i` low, `load_data_o` is zero.
- R11: Size code 11 behaves exactly like the word size code 10 for both loads and stores.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| base_i | input | 32 | Base register value |
| offset_i | input | 32 | Sign-extended immediate offset |
| store_data_i | input | 32 | Register value to be stored |
| size_i | input | 2 | Access size: 00 byte, 01 half-word, 10 or 11 word |
| unsigned_i | input | 1 | 1 = zero-extend narrow loads, 0 = sign-extend them |
| load_en_i | input | 1 | A load is in progress |
| store_en_i | input | 1 | A store is in progress |
| mem_rdata_i | input | 32 | Word returned by the data memory |
| mem_addr_o | output | 30 | Word address sent to the data memory |
| wmask_o | output | 4 | Per-lane write enable, bit k covers data bits [8k+7:8k] |
| wdata_o | output | 32 | Store data after lane replication |
| load_data_o | output | 32 | Extracted and extended load result |

## Verification
The bound checker holds a set of shape rules at every input combination: the number of mask bits set and their grouping for each size, the empty mask when no store is requested, the replication pattern of the write data, the extension bits above a narrow load result, and that word loads pass the memory word through unchanged. Those rules cannot tell whether the right lane was chosen. Only the bench's scenarios show that: stores through the aligner land in a behavioural RAM, and later loads must return exactly the bytes a model of that memory predicts, including lane position, wrap-around of the address sum and the ignored low bits of misaligned accesses.

// File: rtl/lsa_pkg.sv
package lsa_pkg;

    localparam int DATA_W  = 32;
    localparam int LANE_W  = 8;
    localparam int LANES   = DATA_W / LANE_W;
    localparam int OFS_W   = $clog2(LANES);
    localparam int WADDR_W = DATA_W - OFS_W;
    localparam int HALF_W  = 2 * LANE_W;
    localparam int HALVES  = DATA_W / HALF_W;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_WIDE = 2'b11
    } acc_size_e;

    typedef struct packed {
        logic [WADDR_W-1:0] word;
        logic [OFS_W-1:0]   ofs;
    } eaddr_t;

    typedef struct packed {
        logic [LANES-1:0]  mask;
        logic [DATA_W-1:0] data;
    } wr_beat_t;

    function automatic logic is_full(acc_size_e s);
        return (s == SZ_WORD) || (s == SZ_WIDE);
    endfunction

    function automatic logic [DATA_W-1:0] widen_byte(logic [LANE_W-1:0] v, logic zext);
        logic fill;
        fill = zext ? 1'b0 : v[LANE_W-1];
        return {{(DATA_W-LANE_W){fill}}, v};
    endfunction

    function automatic logic [DATA_W-1:0] widen_half(logic [HALF_W-1:0] v, logic zext);
        logic fill;
        fill = zext ? 1'b0 : v[HALF_W-1];
        return {{(DATA_W-HALF_W){fill}}, v};
    endfunction

endpackage

// File: rtl/lsa_addr_gen.sv
module lsa_addr_gen
    import lsa_pkg::*;
(
    input  logic [DATA_W-1:0] base_i,
    input  logic [DATA_W-1:0] offset_i,
    output eaddr_t            ea_o
);

    logic [DATA_W-1:0] sum;

    // Modular add: carries out of the top bit are dropped.
    assign sum  = base_i + offset_i;
    assign ea_o = sum;

endmodule

// File: rtl/lsa_store_lane.sv
module lsa_store_lane
    import lsa_pkg::*;
(
    input  acc_size_e         size_i,
    input  logic              en_i,
    input  logic [OFS_W-1:0]  ofs_i,
    input  logic [DATA_W-1:0] data_i,
    output wr_beat_t          beat_o
);

    logic [LANE_W-1:0] byte_v;
    logic [HALF_W-1:0] half_v;
    logic [LANES-1:0]  mask_v;
    logic [DATA_W-1:0] data_v;

    assign byte_v = data_i[LANE_W-1:0];
    assign half_v = data_i[HALF_W-1:0];

    for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
        localparam logic [OFS_W-1:0] LIDX = OFS_W'(gi);
        localparam int               HSUB = gi % 2;
        logic hit;

        assign hit = is_full(size_i)
                   || ((size_i == SZ_HALF) && (LIDX[OFS_W-1] == ofs_i[OFS_W-1]))
                   || ((size_i == SZ_BYTE) && (LIDX == ofs_i));

        assign mask_v[gi] = en_i & hit;

        always_comb begin
            unique case (size_i)
                SZ_BYTE: data_v[gi*LANE_W +: LANE_W] = byte_v;
                SZ_HALF: data_v[gi*LANE_W +: LANE_W] = half_v[HSUB*LANE_W +: LANE_W];
                default: data_v[gi*LANE_W +: LANE_W] = data_i[gi*LANE_W +: LANE_W];
            endcase
        end
    end

    assign beat_o = '{mask: mask_v, data: data_v};

endmodule

// File: rtl/lsa_load_extract.sv
module lsa_load_extract
    import lsa_pkg::*;
(
    input  acc_size_e         size_i,
    input  logic              zext_i,
    input  logic              en_i,
    input  logic [OFS_W-1:0]  ofs_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic [DATA_W-1:0] data_o
);

    logic [LANE_W-1:0] lane_b [LANES];
    logic [HALF_W-1:0] lane_h [HALVES];
    logic [LANE_W-1:0] sel_b;
    logic [HALF_W-1:0] sel_h;

    for (genvar gb = 0; gb < LANES; gb++) begin : g_byte
        assign lane_b[gb] = rdata_i[gb*LANE_W +: LANE_W];
    end

    for (genvar gh = 0; gh < HALVES; gh++) begin : g_half
        assign lane_h[gh] = rdata_i[gh*HALF_W +: HALF_W];
    end

    assign sel_b = lane_b[ofs_i];
    assign sel_h = lane_h[ofs_i[OFS_W-1]];

    always_comb begin
        unique case (size_i)
            SZ_BYTE: data_o = widen_byte(sel_b, zext_i);
            SZ_HALF: data_o = widen_half(sel_h, zext_i);
            default: data_o = rdata_i;
        endcase
        if (!en_i) begin
            data_o = '0;
        end
    end

endmodule

// File: rtl/lsu_lane_aligner.sv
module lsu_lane_aligner
    import lsa_pkg::*;
(
    input  logic [31:0] base_i,
    input  logic [31:0] offset_i,
    input  logic [31:0] store_data_i,
    input  logic [1:0]  size_i,
    input  logic        unsigned_i,
    input  logic        load_en_i,
    input  logic        store_en_i,
    input  logic [31:0] mem_rdata_i,
    output logic [29:0] mem_addr_o,
    output logic [3:0]  wmask_o,
    output logic [31:0] wdata_o,
    output logic [31:0] load_data_o
);

    eaddr_t    ea;
    wr_beat_t  beat;
    acc_size_e size;

    assign size = acc_size_e'(size_i);

    lsa_addr_gen u_addr (
        .base_i   (base_i),
        .offset_i (offset_i),
        .ea_o     (ea)
    );

    lsa_store_lane u_store (
        .size_i (size),
        .en_i   (store_en_i),
        .ofs_i  (ea.ofs),
        .data_i (store_data_i),
        .beat_o (beat)
    );

    lsa_load_extract u_load (
        .size_i  (size),
        .zext_i  (unsigned_i),
        .en_i    (load_en_i),
        .ofs_i   (ea.ofs),
        .rdata_i (mem_rdata_i),
        .data_o  (load_data_o)
    );

    assign mem_addr_o = ea.word;
    assign wmask_o    = beat.mask;
    assign wdata_o    = beat.data;

endmodule

// File: rtl/lsa_checker.sv
module lsa_checker (
    input logic [31:0] base_i,
    input logic [31:0] offset_i,
    input logic [31:0] store_data_i,
    input logic [1:0]  size_i,
    input logic        unsigned_i,
    input logic        load_en_i,
    input logic        store_en_i,
    input logic [31:0] mem_rdata_i,
    input logic [29:0] mem_addr_o,
    input logic [3:0]  wmask_o,
    input logic [31:0] wdata_o,
    input logic [31:0] load_data_o
);

    logic [31:0] ea_chk;
    assign ea_chk = base_i + offset_i;

    always_comb begin
        AST_WORD_ADDR: assert (mem_addr_o == ea_chk[31:2]) else $error("word address"); // R1

        if (!store_en_i) begin
            AST_MASK_IDLE: assert (wmask_o == 4'b0000) else $error("mask while idle"); // R5
        end
        if (store_en_i && size_i == 2'b00) begin
            AST_BYTE_MASK: assert ($countones(wmask_o) == 1 && wdata_o == {4{store_data_i[7:0]}}) else $error("byte store shape"); // R2
        end
        if (store_en_i && size_i == 2'b01) begin
            AST_HALF_MASK: assert ((wmask_o == 4'b0011 || wmask_o == 4'b1100) && wdata_o == {2{store_data_i[15:0]}}) else $error("half store shape"); // R3
        end
        if (store_en_i && size_i[1]) begin
            AST_WORD_MASK: assert (wmask_o == 4'b1111 && wdata_o == store_data_i) else $error("word store shape"); // R4
        end

        if (!load_en_i) begin
            AST_LOAD_IDLE: assert (load_data_o == 32'h0) else $error("load data while idle"); // R10
        end
        if (load_en_i && size_i == 2'b00 && !unsigned_i) begin
            AST_BYTE_SEXT: assert (load_data_o[31:8] == {24{load_data_o[7]}}) else $error("byte sign fill"); // R6
        end
        if (load_en_i && size_i == 2'b00 && unsigned_i) begin
            AST_BYTE_ZEXT: assert (load_data_o[31:8] == 24'h0) else $error("byte zero fill"); // R7
        end
        if (load_en_i && size_i == 2'b01) begin
            AST_HALF_FILL: assert (load_data_o[31:16] == (unsigned_i ? 16'h0 : {16{load_data_o[15]}})) else $error("half fill"); // R8
        end
        if (load_en_i && size_i[1]) begin
            AST_WORD_PASS: assert (load_data_o == mem_rdata_i) else $error("word load"); // R9 R11
        end
    end

endmodule

bind lsu_lane_aligner lsa_checker u_chk (
    .base_i       (base_i),
    .offset_i     (offset_i),
    .store_data_i (store_data_i),
    .size_i       (size_i),
    .unsigned_i   (unsigned_i),
    .load_en_i    (load_en_i),
    .store_en_i   (store_en_i),
    .mem_rdata_i  (mem_rdata_i),
    .mem_addr_o   (mem_addr_o),
    .wmask_o      (wmask_o),
    .wdata_o      (wdata_o),
    .load_data_o  (load_data_o)
);

// File: tb/tb_lsu_lane_aligner.sv
module tb_lsu_lane_aligner;

    localparam int CLK_PERIOD = 10;
    localparam int RAM_WORDS  = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;

    logic [31:0] base_i = '0, offset_i = '0, store_data_i = '0, mem_rdata_i;
    logic [1:0]  size_i = '0;
    logic        unsigned_i = 1'b0, load_en_i = 1'b0, store_en_i = 1'b0;
    logic [29:0] mem_addr_o;
    logic [3:0]  wmask_o;
    logic [31:0] wdata_o, load_data_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    lsu_lane_aligner dut (
        .base_i(base_i), .offset_i(offset_i), .store_data_i(store_data_i),
        .size_i(size_i), .unsigned_i(unsigned_i), .load_en_i(load_en_i),
        .store_en_i(store_en_i), .mem_rdata_i(mem_rdata_i), .mem_addr_o(mem_addr_o),
        .wmask_o(wmask_o), .wdata_o(wdata_o), .load_data_o(load_data_o)
    );

    function automatic logic [31:0] seed_word(int k);
        return 32'hA55A_F00F ^ (k * 32'h0101_0101);
    endfunction

    // Behavioural RAM driven by the aligner's outputs.
    logic [31:0] ram [RAM_WORDS];
    assign mem_rdata_i = ram[mem_addr_o[3:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < RAM_WORDS; k++) ram[k] <= seed_word(k);
        end else begin
            for (int ln = 0; ln < 4; ln++)
                if (wmask_o[ln]) ram[mem_addr_o[3:0]][ln*8 +: 8] <= wdata_o[ln*8 +: 8];
        end
    end

    // Bench-side memory model, updated from requirement-derived expectations.
    logic [31:0] model [RAM_WORDS];

    typedef struct {
        string       tag;
        logic [29:0] addr;
        logic [3:0]  mask;
        logic [31:0] wd;
        logic        chk_wd;
        logic [31:0] ld;
    } exp_t;

    exp_t sb_q [$];
    int   checks = 0;
    int   failures = 0;
    bit   done = 0;

    task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    // Driver: applies one access and queues what the ports must show.
    task automatic op(string tag, logic ld, logic st, logic [1:0] sz, logic uns,
                      logic [31:0] b, logic [31:0] o, logic [31:0] sd);
        exp_t        e;
        logic [31:0] ea, w;
        logic [1:0]  lo;
        logic [7:0]  by;
        logic [15:0] hw;
        @(posedge clk);
        #1;
        base_i = b; offset_i = o; store_data_i = sd; size_i = sz;
        unsigned_i = uns; load_en_i = ld; store_en_i = st;
        ea = b + o;
        lo = ea[1:0];
        e.tag = tag;
        e.addr = ea[31:2];
        e.chk_wd = st;
        case (sz)
            2'b00: begin e.mask = 4'b0001 << lo; e.wd = {sd[7:0], sd[7:0], sd[7:0], sd[7:0]}; end
            2'b01: begin e.mask = lo[1] ? 4'b1100 : 4'b0011; e.wd = {sd[15:0], sd[15:0]}; end
            default: begin e.mask = 4'b1111; e.wd = sd; end
        endcase
        if (!st) e.mask = 4'b0000;
        w = model[ea[5:2]];
        case (sz)
            2'b00: begin
                by = w[lo*8 +: 8];
                e.ld = uns ? {24'h0, by} : {{24{by[7]}}, by};
            end
            2'b01: begin
                hw = lo[1] ? w[31:16] : w[15:0];
                e.ld = uns ? {16'h0, hw} : {{16{hw[15]}}, hw};
            end
            default: e.ld = w;
        endcase
        if (!ld) e.ld = 32'h0;
        for (int ln = 0; ln < 4; ln++)
            if (e.mask[ln]) model[ea[5:2]][ln*8 +: 8] = e.wd[ln*8 +: 8];
        sb_q.push_back(e);
    endtask

    // Monitor: compares ports mid-cycle against the oldest queued item.
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                e = sb_q.pop_front();
                cmp(e.tag, "addr", {2'b00, mem_addr_o}, {2'b00, e.addr});
                cmp(e.tag, "mask", {28'h0, wmask_o}, {28'h0, e.mask});
                if (e.chk_wd) cmp(e.tag, "wdata", wdata_o, e.wd);
                cmp(e.tag, "load", load_data_o, e.ld);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < RAM_WORDS; k++) model[k] = seed_word(k);
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // Reset/idle state: no strobes, R5 empty mask, R10 zero load.
        op("R5_R10_idle", 0, 0, 2'b10, 0, 32'h100, 32'h8, 32'hFFFF_FFFF);
        // Strobes low with a live address and data.
        op("R5_no_store", 0, 0, 2'b00, 0, 32'h104, 32'h1, 32'h0000_00EE);
        op("R10_no_load", 0, 0, 2'b00, 0, 32'h104, 32'h3, 32'h0);

        // R4 word store, aligned and with ignored low bits.
        op("R4_sw", 0, 1, 2'b10, 0, 32'h100, 32'h8, 32'h1122_3344);
        op("R4_sw_lowbits", 0, 1, 2'b10, 0, 32'h10C, 32'h3, 32'h5566_7788);
        // R11 size 11 acts as a word.
        op("R11_wide_store", 0, 1, 2'b11, 0, 32'h110, 32'h0, 32'hCAFE_BABE);

        // R2 byte stores into every lane of word 5.
        op("R2_sb_lane0", 0, 1, 2'b00, 0, 32'h114, 32'h0, 32'h1234_56C0);
        op("R2_sb_lane1", 0, 1, 2'b00, 0, 32'h114, 32'h1, 32'hABCD_EF41);
        op("R2_sb_lane2", 0, 1, 2'b00, 0, 32'h114, 32'h2, 32'h0000_0092);
        op("R2_sb_lane3", 0, 1, 2'b00, 0, 32'h114, 32'h3, 32'hFFFF_FF03);

        // R3 half stores; address bit 0 ignored.
        op("R3_sh_low_a0", 0, 1, 2'b01, 0, 32'h118, 32'h1, 32'hBEEF_8001);
        op("R3_sh_high", 0, 1, 2'b01, 0, 32'h118, 32'h2, 32'h0000_7F22);

        // R1 address wrap and negative offset, read back as words (R9).
        op("R1_wrap_lw", 1, 0, 2'b10, 0, 32'hFFFF_FFF0, 32'h24, 32'h0);
        op("R1_neg_off_lw", 1, 0, 2'b10, 0, 32'h200, 32'hFFFF_FFFC, 32'h0);

        // R6 / R7 byte loads on each lane of word 5.
        for (int ln = 0; ln < 4; ln++) begin
            op("R6_lb", 1, 0, 2'b00, 0, 32'h114, 32'(ln), 32'h0);
            op("R7_lbu", 1, 0, 2'b00, 1, 32'h114, 32'(ln), 32'h0);
        end

        // R8 half loads on both halves, with address bit 0 set on the upper one.
        op("R8_lh_low", 1, 0, 2'b01, 0, 32'h118, 32'h0, 32'h0);
        op("R8_lhu_low", 1, 0, 2'b01, 1, 32'h118, 32'h0, 32'h0);
        op("R8_lh_high_a0", 1, 0, 2'b01, 0, 32'h118, 32'h3, 32'h0);
        op("R8_lhu_high_a0", 1, 0, 2'b01, 1, 32'h118, 32'h3, 32'h0);

        // R9 word load with unsigned flag set; R11 wide load.
        op("R9_lw_uns", 1, 0, 2'b10, 1, 32'h108, 32'h0, 32'h0);
        op("R9_lw_misaligned", 1, 0, 2'b10, 0, 32'h10C, 32'h2, 32'h0);
        op("R11_wide_load", 1, 0, 2'b11, 0, 32'h110, 32'h0, 32'h0);

        // R10 load strobe low on a non-zero word.
        op("R10_load_off", 0, 0, 2'b10, 0, 32'h110, 32'h0, 32'h0);

        @(posedge clk);
        #1 load_en_i = 0; store_en_i = 0;
        wait (sb_q.size() == 0);
        @(posedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule